// File: doc/BRIEF.md
# SPI Slave Byte Receiver with Flow-Control Wait Line

This block is the receiving end of a serial link on which an external SPI master pushes a stream of boot-image bytes into the chip. The serial clock, data and active-low select pins are brought into the system clock domain through flop synchronizers. Data is captured on the rising edge of the serial clock, most significant bit first, in SPI mode 0. Each completed byte goes into a small FIFO. A slower consumer drains the FIFO through a valid/ready handshake.

The receiver does not trust the master to pace itself. It drives a wait line that the master must sample before it sends each byte. The line is raised early enough that a byte already in flight still finds room. It is also held high for as long as reset is applied. If a byte completes while the FIFO is full, the byte is dropped and a sticky overrun flag is set. Releasing select in the middle of a byte throws away the partial bits. A select line that is left floating is pulled high and so reads as not selected.

Top module: `spi_rx_hostwait`

## Requirements
- R1: While rstN is low, hostWait is 1. After reset, outValid and overrun are 0.
- R2: Bits are sampled on rising sclk edges while ssN is 0, most significant bit first. Eight edges form one byte, which appears on outData.
- R3: Bytes leave in arrival order. A byte is removed only in a cycle where outValid and outReady are both 1. While outValid is 1 and outReady is 0, outData holds its value.
- R4: hostWait is 1 exactly when the FIFO holds DEPTH-1 or more bytes (3 or more with the default depth of 4), and 0 otherwise.
- R5: A byte completed while the FIFO holds DEPTH bytes is discarded and sets overrun to 1. The bytes already stored are unchanged.
- R6: Raising ssN before the eighth edge discards the partial byte. The next selected transfer starts again at its most significant bit.
- R7: sclk edges while ssN is 1 produce no byte and do not disturb the next transfer.
- R8: Once overrun is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| mosi | input | 1 | Serial data from the master |
| ssN | input | 1 | Active-low slave select (pulled high when floating) |
| hostWait | output | 1 | 1 tells the master not to start another byte |
| outData | output | DATA_W | Head byte of the FIFO |
| outValid | output | 1 | FIFO holds at least one byte |
| outReady | input | 1 | Consumer accepts the head byte |
| overrun | output | 1 | Sticky flag: a byte was lost because the FIFO was full |

## Verification
The assertions assume the master runs each serial-clock phase for several system clocks, longer than the synchronizer delay. They also assume mosi is stable around each rising edge, so that each synchronized edge carries one well-defined bit. The bench drives every phase for eight system clocks and changes mosi only while sclk is low. It honours hostWait in every sequence except the one that deliberately overfills the FIFO to provoke an overrun.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // Strobes from the control path to the datapath, one system clock wide.
  typedef struct packed {
    logic shiftEn;      // take shiftBit into the shift register
    logic shiftBit;     // synchronized serial data bit
    logic byteDone;     // this shift completes a byte
    logic dropPartial;  // select released with a partial byte pending
  } rxStrobe_t;
endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       ssN,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;
  logic [SYNC_STAGES-1:0] ssPipe;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;

  logic sclkS, mosiS, ssS, sclkRise, selected;

  // The three pins go through equal-length chains so that they stay aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      mosiPipe <= '0;
      ssPipe   <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssN};
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign ssS      = ssPipe[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev;
  assign selected = ~ssS;

  always_comb begin
    strobe.shiftEn     = selected & sclkRise;
    strobe.shiftBit    = mosiS;
    strobe.byteDone    = selected & sclkRise & (bitCnt == LAST_BIT);
    strobe.dropPartial = ~selected & (bitCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!selected) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  // R6: once deselection is seen, the next byte starts from its first bit
  p_partial_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    ssS |=> (bitCnt == '0));

  // R7: no shift strobe while deselected
  p_idle_no_shift_r7: assert property (@(posedge clk) disable iff (!rstN)
    ssS |-> !strobe.shiftEn);
endmodule

// File: rtl/spi_rx_datapath.sv
module spi_rx_datapath
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              hostWait,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WAIT_CNT = CNT_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] newByte;
  logic              push, pop, full;

  assign newByte = {shReg[DATA_W-2:0], strobe.shiftBit};
  assign full    = (count == FULL_CNT);
  assign push    = strobe.byteDone & ~full;
  assign pop     = outValid & outReady;

  // Shift register, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.dropPartial) begin
      shReg <= '0;
    end else if (strobe.shiftEn) begin
      shReg <= newByte;
    end
  end

  // FIFO storage, not reset
  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= newByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           overrun <= 1'b0;
    else if (strobe.byteDone && full)    overrun <= 1'b1;
  end

  assign outData  = fifoMem[rdPtr];
  assign outValid = (count != '0);
  assign hostWait = ~rstN | (count >= WAIT_CNT);

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R5: a byte arriving at a full FIFO raises the flag
  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.byteDone && full) |=> overrun);

  // R8: the flag never falls outside reset
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R3: stalled head byte stays put
  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R4: a full FIFO was announced by the wait line one cycle earlier
  p_wait_before_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (full && !$past(full)) |-> $past(hostWait));
endmodule

// File: rtl/spi_rx_hostwait.sv
module spi_rx_hostwait
  import spi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ssN,
  output logic              hostWait,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              overrun
);
  rxStrobe_t strobe;

  spi_rx_ctrl #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .mosi   (mosi),
    .ssN    (ssN),
    .strobe (strobe)
  );

  spi_rx_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outData  (outData),
    .outValid (outValid),
    .outReady (outReady),
    .hostWait (hostWait),
    .overrun  (overrun)
  );

  // R1: the master is held off throughout reset
  always_comb begin
    if (!rstN) p_wait_in_reset_r1: assert (hostWait);
  end
endmodule

// File: tb/spi_rx_hostwait_tb.sv
module spi_rx_hostwait_tb_top;
  localparam int DEPTH = 4;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rstN, sclk, mosi, ssN, outReady;
  logic hostWait, outValid, overrun;
  logic [7:0] outData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_rx_hostwait #(.DATA_W(8), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .ssN(ssN),
    .hostWait(hostWait), .outData(outData), .outValid(outValid),
    .outReady(outReady), .overrun(overrun)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int nbits);
    ssN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7-i];
      waitN(HALF);
      sclk = 1'b1;
      waitN(HALF);
      sclk = 1'b0;
    end
    waitN(HALF);
    ssN = 1'b1;
    waitN(HALF);
  endtask

  task automatic popCheck(input logic [7:0] exp, input string req);
    int t = 0;
    while (!outValid && t < 100) begin
      waitN(1);
      t++;
    end
    check(outValid == 1'b1, req, int'(outValid), 1);
    check(outData == exp, req, int'(outData), int'(exp));
    outReady = 1'b1;
    waitN(1);
    outReady = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitN(3);
    check(hostWait == 1'b1, "R1 hostWait in reset", int'(hostWait), 1);
    rstN = 1'b1;
    waitN(4);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(overrun == 1'b0, "R1 overrun after reset", int'(overrun), 0);
  endtask

  initial begin
    sclk = 1'b0; mosi = 1'b0; ssN = 1'b1; outReady = 1'b0; rstN = 1'b0;
    waitN(2);
    doReset();
    check(hostWait == 1'b0, "R4 empty fifo wait low", int'(hostWait), 0);

    // R2/R3/R4: sweep every byte value, three per group
    for (int g = 0; g < 86; g++) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        check(hostWait == (k >= DEPTH - 1), "R4 wait before send", int'(hostWait), int'(k >= DEPTH - 1));
        sendBits(8'((3 * g + k) & 8'hFF), 8);
      end
      check(hostWait == 1'b1, "R4 wait at DEPTH-1", int'(hostWait), 1);
      if (g == 0) begin
        // R3: head held while the consumer stalls
        for (int s = 0; s < 5; s++) begin
          waitN(1);
          check(outData == 8'h00 && outValid, "R3 stalled head", int'(outData), 0);
        end
      end
      for (int k = 0; k < DEPTH - 1; k++) begin
        popCheck(8'((3 * g + k) & 8'hFF), "R2 R3 byte order");
        check(hostWait == 1'b0, "R4 wait released", int'(hostWait), 0);
      end
    end
    check(outValid == 1'b0, "R3 fifo drained", int'(outValid), 0);

    // R6: partial byte dropped on deselect
    sendBits(8'hFF, 5);
    waitN(10);
    check(outValid == 1'b0, "R6 partial dropped", int'(outValid), 0);
    sendBits(8'h3C, 8);
    popCheck(8'h3C, "R6 fresh byte after drop");

    // R7: clocks while deselected are ignored
    ssN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mosi = i[0];
      waitN(HALF); sclk = 1'b1; waitN(HALF); sclk = 1'b0;
    end
    waitN(10);
    check(outValid == 1'b0, "R7 no byte while idle", int'(outValid), 0);
    sendBits(8'h81, 8);
    popCheck(8'h81, "R7 alignment kept");

    // R5: overfill
    sendBits(8'h11, 8); sendBits(8'h22, 8); sendBits(8'h33, 8); sendBits(8'h44, 8);
    check(overrun == 1'b0, "R5 no overrun at full", int'(overrun), 0);
    sendBits(8'h55, 8);
    check(overrun == 1'b1, "R5 overrun set", int'(overrun), 1);
    popCheck(8'h11, "R5 stored kept");
    popCheck(8'h22, "R5 stored kept");
    popCheck(8'h33, "R5 stored kept");
    popCheck(8'h44, "R5 stored kept");
    waitN(2);
    check(outValid == 1'b0, "R5 extra byte discarded", int'(outValid), 0);

    // R8: sticky until reset
    sendBits(8'h66, 8);
    popCheck(8'h66, "R8 traffic after overrun");
    check(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
    doReset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule